// File: doc/BRIEF.md
# Block-Transfer Channel Command Executor

This block runs one IO channel command at a time. A 36-bit command word is presented together with a one-cycle load strobe. The block splits the word into three parts: a 3-bit operation code, a 15-bit word count and a 15-bit starting address. It then moves that many words in one direction. Either it takes words from a device source and writes them to memory, or it reads words from memory and hands them to a device sink. One word moves at a time, and each word passes through a single 36-bit data register.

After each word, the address counter steps up by one and the word counter steps down by one. When the count reaches zero, the block gives a single-cycle end pulse. The operation code selects which pulse: a disconnect pulse, which tells the CPU the channel has stopped, or a request for the next command word. The block then returns to idle and waits for the next load. The memory port has a fixed timing: it accepts every request, and read data is valid in the cycle after a read request.

Top module: `chan_exec`

## Requirements
- R1: The command word fields are: operation code = bits 35:33, word count = bits 32:18, start address = bits 14:0. Bits 17:15 and operation bit 34 are ignored.
- R2: Operation bit 35 sets the direction: 1 = device to memory (writes), 0 = memory to device (reads). Operation bit 33 sets the end action: 1 = disconnect, 0 = request the next command.
- R3: Successive words use ascending consecutive memory addresses, starting at the command's start address.
- R4: The address counter wraps from 0x7FFF to 0x0000.
- R5: A command with count N moves exactly N words (N memory accesses and N device handshakes), then ends.
- R6: At the end of a command, exactly one of `cmd_req` or `disc` pulses for one cycle. `busy` is low from the following cycle on.
- R7: A command with count zero raises its end pulse in the first cycle after the load and makes no memory request.
- R8: A memory write is issued only while the data register holds a word taken from the device. While the device withholds data, no memory request is made.
- R9: A load while busy abandons the current command, including any word held in the data register, and starts the new command.
- R10: After reset: `busy`, `mem_req`, `dev_in_ready`, `dev_out_valid`, `cmd_req` and `disc` are all low.
- R11: While `dev_out_valid` is high and `dev_out_ready` is low, `dev_out_valid` and `dev_out_data` stay unchanged.
- R12: A read word is taken from `mem_rdata` one cycle after its read request, and is offered to the device unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_load | input | 1 | One-cycle strobe: accept `cmd_word` |
| cmd_word | input | 36 | Packed command word |
| dev_in_valid | input | 1 | Device source has a word |
| dev_in_data | input | 36 | Device source word |
| dev_in_ready | output | 1 | Channel accepts a source word |
| dev_out_valid | output | 1 | Channel offers a word to the sink |
| dev_out_data | output | 36 | Word offered to the sink |
| dev_out_ready | input | 1 | Sink accepts the word |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data, one cycle after a read request |
| busy | output | 1 | A command is in progress |
| cmd_req | output | 1 | End pulse: next command wanted |
| disc | output | 1 | End pulse: channel disconnected |

## Verification
The assertions check on every cycle the following properties:
- Each counter step is exact: the address goes up by one modulo 2^15, and the count goes down by one and never steps from zero.
- Writes happen only with a valid device word held in the data register.
- The end pulses are exclusive and are followed by idle.
- A zero-count load ends at once.
- The sink sees stable data while it stalls.

Only the bench's scenarios can show the end-to-end results:
- the exact address sequence and data order in both directions, including the wrap past 0x7FFF;
- that ignored command bits change nothing;
- that a device stall issues no memory request;
- that a mid-command reload discards the old transfer.

// File: rtl/chan_pkg.sv
// Package: shared widths, command field positions and controller state type.
// Assumes a 36-bit command word and a 15-bit word-addressed memory.
package chan_pkg;
    parameter int WORD_W = 36;
    parameter int ADDR_W = 15;
    parameter int CNT_W  = 15;
    parameter int OP_W   = 3;

    localparam int OP_LSB  = WORD_W - OP_W;     // operation code at the top
    localparam int CNT_LSB = OP_LSB - CNT_W;    // count right below it
    localparam int ADR_LSB = 0;                 // address at the bottom

    localparam int OP_DIR_BIT  = OP_W - 1;      // 1 = device to memory
    localparam int OP_DISC_BIT = 0;             // 1 = disconnect at end

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN_WAIT,
        ST_IN_WR,
        ST_OUT_REQ,
        ST_OUT_CAP,
        ST_OUT_SEND,
        ST_END
    } chan_state_t;
endpackage

// File: rtl/chan_fields.sv
// Module: splits a packed command word into operation, count and address.
// Assumes the layout in chan_pkg; the spare bits are deliberately unused.
module chan_fields
    import chan_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output logic [OP_W-1:0]   op,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] adr,
    output logic              cnt_zero
);
    logic unused_spare;

    // Extract the three fields and flag an empty count.
    always_comb begin
        op           = cmd_word[OP_LSB +: OP_W];
        cnt          = cmd_word[CNT_LSB +: CNT_W];
        adr          = cmd_word[ADR_LSB +: ADDR_W];
        cnt_zero     = (cmd_word[CNT_LSB +: CNT_W] == '0);
        unused_spare = ^cmd_word[CNT_LSB-1:ADR_LSB+ADDR_W];
    end
endmodule

// File: rtl/chan_regs.sv
// Module: operation register, down-counting word counter, up-counting
// address counter. A load has priority over a step. Assumes step is only
// raised while the count is nonzero.
module chan_regs
    import chan_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int OW = OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [OW-1:0] op_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [AW-1:0] adr_in,
    input  logic          step,
    output logic [OW-1:0] op_q,
    output logic [CW-1:0] cnt_q,
    output logic [AW-1:0] adr_q,
    output logic          cnt_last
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [AW-1:0] ADR_ONE = AW'(1);

    // Capture command fields on load, otherwise step both counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            cnt_q <= '0;
            adr_q <= '0;
        end else if (load) begin
            op_q  <= op_in;
            cnt_q <= cnt_in;
            adr_q <= adr_in;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_ONE;
            adr_q <= adr_q + ADR_ONE;
        end
    end

    // Flag the final word of the block.
    always_comb cnt_last = (cnt_q == CNT_ONE);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (adr_q == $past(adr_q) + ADR_ONE)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R5
    AST_NO_STEP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/chan_datareg.sv
// Module: the single data register every word passes through, with a
// valid flag. A flush (new command) wins over everything else.
module chan_datareg
    import chan_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          take_dev,
    input  logic          take_mem,
    input  logic          drop,
    input  logic [DW-1:0] dev_data,
    input  logic [DW-1:0] mem_data,
    output logic [DW-1:0] q,
    output logic          vld
);
    // Hold one word and track whether it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q   <= '0;
            vld <= 1'b0;
        end else if (take_dev) begin
            q   <= dev_data;
            vld <= 1'b1;
        end else if (take_mem) begin
            q   <= mem_data;
            vld <= 1'b1;
        end else if (drop) begin
            vld <= 1'b0;
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_dev && take_mem)); // R12
endmodule

// File: rtl/chan_ctrl.sv
// Module: transfer sequencer. Input commands loop wait-for-device then
// write; output commands loop read, capture, offer. Assumes memory accepts
// every request and returns read data one cycle after it.
module chan_ctrl
    import chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_load,
    input  logic new_dir_in,
    input  logic new_cnt_zero,
    input  logic op_disc,
    input  logic cnt_last,
    input  logic dvld,
    input  logic dev_in_valid,
    input  logic dev_out_ready,
    output logic dev_in_ready,
    output logic dev_out_valid,
    output logic mem_req,
    output logic mem_we,
    output logic take_dev,
    output logic take_mem,
    output logic drop,
    output logic step,
    output logic cmd_req,
    output logic disc,
    output logic busy
);
    chan_state_t state, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and per-state controls.
    always_comb begin
        state_nx      = state;
        dev_in_ready  = 1'b0;
        dev_out_valid = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        take_dev      = 1'b0;
        take_mem      = 1'b0;
        drop          = 1'b0;
        step          = 1'b0;
        cmd_req       = 1'b0;
        disc          = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_IN_WAIT: begin
                dev_in_ready = !dvld && !cmd_load;
                if (dev_in_valid && !dvld && !cmd_load) begin
                    take_dev = 1'b1;
                    state_nx = ST_IN_WR;
                end
            end
            ST_IN_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                step     = 1'b1;
                drop     = 1'b1;
                state_nx = cnt_last ? ST_END : ST_IN_WAIT;
            end
            ST_OUT_REQ: begin
                mem_req  = 1'b1;
                state_nx = ST_OUT_CAP;
            end
            ST_OUT_CAP: begin
                take_mem = 1'b1;
                state_nx = ST_OUT_SEND;
            end
            ST_OUT_SEND: begin
                dev_out_valid = dvld;
                if (dvld && dev_out_ready) begin
                    step     = 1'b1;
                    drop     = 1'b1;
                    state_nx = cnt_last ? ST_END : ST_OUT_REQ;
                end
            end
            ST_END: begin
                disc     = op_disc;
                cmd_req  = !op_disc;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (cmd_load) begin
            if (new_cnt_zero)    state_nx = ST_END;
            else if (new_dir_in) state_nx = ST_IN_WAIT;
            else                 state_nx = ST_OUT_REQ;
        end
    end

    // Busy whenever a command is in progress.
    always_comb busy = (state != ST_IDLE);

    AST_END_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_req, disc})); // R6
    AST_END_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_req || disc) && !cmd_load) |=> !busy); // R6
    AST_ZERO_ENDS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && new_cnt_zero) |=> ((cmd_req || disc) && !mem_req)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || dev_in_ready || dev_out_valid)); // R10
endmodule

// File: rtl/chan_exec.sv
// Module: top of the channel command executor. Wires the field splitter,
// the counters, the data register and the sequencer to the pins.
// Assumes a single-cycle command load strobe and fixed-latency memory.
module chan_exec
    import chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              dev_in_valid,
    input  logic [WORD_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [WORD_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              cmd_req,
    output logic              disc
);
    logic [OP_W-1:0]   f_op, op_q;
    logic [CNT_W-1:0]  f_cnt, cnt_q;
    logic [ADDR_W-1:0] f_adr, adr_q;
    logic              f_zero, cnt_last;
    logic              take_dev, take_mem, drop, step;
    logic [WORD_W-1:0] dreg_q;
    logic              dreg_vld;

    chan_fields u_fields (
        .cmd_word (cmd_word),
        .op       (f_op),
        .cnt      (f_cnt),
        .adr      (f_adr),
        .cnt_zero (f_zero)
    );

    chan_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .op_in    (f_op),
        .cnt_in   (f_cnt),
        .adr_in   (f_adr),
        .step     (step),
        .op_q     (op_q),
        .cnt_q    (cnt_q),
        .adr_q    (adr_q),
        .cnt_last (cnt_last)
    );

    chan_datareg u_dreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cmd_load),
        .take_dev (take_dev),
        .take_mem (take_mem),
        .drop     (drop),
        .dev_data (dev_in_data),
        .mem_data (mem_rdata),
        .q        (dreg_q),
        .vld      (dreg_vld)
    );

    chan_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_load      (cmd_load),
        .new_dir_in    (f_op[OP_DIR_BIT]),
        .new_cnt_zero  (f_zero),
        .op_disc       (op_q[OP_DISC_BIT]),
        .cnt_last      (cnt_last),
        .dvld          (dreg_vld),
        .dev_in_valid  (dev_in_valid),
        .dev_out_ready (dev_out_ready),
        .dev_in_ready  (dev_in_ready),
        .dev_out_valid (dev_out_valid),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .take_dev      (take_dev),
        .take_mem      (take_mem),
        .drop          (drop),
        .step          (step),
        .cmd_req       (cmd_req),
        .disc          (disc),
        .busy          (busy)
    );

    // Drive the memory and sink data from the counters and data register.
    always_comb begin
        mem_addr     = adr_q;
        mem_wdata    = dreg_q;
        dev_out_data = dreg_q;
    end

    AST_WE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> dreg_vld); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready && !cmd_load)
            |=> (dev_out_valid && $stable(dev_out_data))); // R11
endmodule

// File: tb/sim_chan_exec.sv
`timescale 1ns/1ps
module sim_chan_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_load = 1'b0;
    logic [35:0] cmd_word = '0;
    logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
    logic [35:0] dev_in_data, dev_out_data, mem_wdata;
    logic        mem_req, mem_we, busy, cmd_req, disc;
    logic [14:0] mem_addr;
    logic [35:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    chan_exec u0 (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_word(cmd_word),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .cmd_req(cmd_req), .disc(disc)
    );

    function automatic logic [35:0] src_word(int i);
        return {4'h9, 16'(i * 3 + 1), 16'hC3C3};
    endfunction
    function automatic logic [35:0] rd_word(logic [14:0] a);
        return {6'h2A, a, a};
    endfunction
    function automatic logic [35:0] mk(logic [2:0] op, logic [14:0] n,
                                       logic [14:0] a, logic [2:0] spare);
        return {op, n, spare, a};
    endfunction

    // Device source, sink and memory models; event logs.
    int          src_idx = 0, src_limit = 0;
    logic        src_en = 1'b0, bp_en = 1'b0, sink_rdy = 1'b1;
    int          wcnt = 0, rcnt = 0, ocnt = 0, reqs = 0, ends_req = 0, ends_disc = 0;
    logic [14:0] wlog_a [0:15];
    logic [35:0] wlog_d [0:15];
    logic [14:0] rlog_a [0:15];
    logic [35:0] olog_d [0:15];

    assign dev_in_valid  = src_en && (src_idx < src_limit);
    assign dev_in_data   = src_word(src_idx);
    assign dev_out_ready = sink_rdy;

    always @(posedge clk) begin
        if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
        if (mem_req) reqs <= reqs + 1;
        if (mem_req && mem_we && wcnt < 16) begin
            wlog_a[wcnt] <= mem_addr; wlog_d[wcnt] <= mem_wdata; wcnt <= wcnt + 1;
        end
        if (mem_req && !mem_we) begin
            mem_rdata <= rd_word(mem_addr);
            if (rcnt < 16) rlog_a[rcnt] <= mem_addr;
            rcnt <= rcnt + 1;
        end
        if (dev_out_valid && dev_out_ready && ocnt < 16) begin
            olog_d[ocnt] <= dev_out_data; ocnt <= ocnt + 1;
        end
        if (cmd_req) ends_req <= ends_req + 1;
        if (disc) ends_disc <= ends_disc + 1;
        sink_rdy <= bp_en ? ~sink_rdy : 1'b1;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk);
        src_idx = 0; src_limit = 0; src_en = 1'b0; bp_en = 1'b0;
        wcnt = 0; rcnt = 0; ocnt = 0; reqs = 0; ends_req = 0; ends_disc = 0;
    endtask

    task automatic issue(logic [35:0] w);
        @(negedge clk);
        cmd_word = w; cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic wait_idle(string req);
        int n = 0;
        while (busy && n < 500) begin @(negedge clk); n++; end
        if (busy) begin
            errors++;
            $display("FAIL %s timeout waiting for idle", req);
        end
        @(negedge clk);
    endtask

    // R10: reset state.
    task automatic t_reset();
        @(negedge clk);
        check("R10 busy", busy, 0);
        check("R10 mem_req", mem_req, 0);
        check("R10 dev_in_ready", dev_in_ready, 0);
        check("R10 dev_out_valid", dev_out_valid, 0);
        check("R10 ends", {cmd_req, disc}, 0);
    endtask

    // R2 R3 R5 R6: device to memory, disconnect at end.
    task automatic t_input();
        clear_logs();
        src_en = 1'b1; src_limit = 4;
        issue(mk(3'b101, 15'd4, 15'h0100, 3'b000));
        wait_idle("R5");
        check("R5 write count", wcnt, 4);
        for (int i = 0; i < 4; i++) begin
            check("R3 write addr", wlog_a[i], 15'h0100 + i);
            check("R2 write data", wlog_d[i], src_word(i));
        end
        check("R6 disc pulses", ends_disc, 1);
        check("R6 req pulses", ends_req, 0);
    endtask

    // R1 R2 R11 R12: memory to device with sink backpressure, spare bits set.
    task automatic t_output();
        clear_logs();
        bp_en = 1'b1;
        issue(mk(3'b010, 15'd3, 15'h0200, 3'b111));
        wait_idle("R5");
        check("R5 read count", rcnt, 3);
        check("R11 sink count", ocnt, 3);
        for (int i = 0; i < 3; i++) begin
            check("R3 read addr", rlog_a[i], 15'h0200 + i);
            check("R12 sink data", olog_d[i], rd_word(15'h0200 + 15'(i)));
        end
        check("R1 no writes", wcnt, 0);
        check("R2 req pulses", ends_req, 1);
        check("R2 disc pulses", ends_disc, 0);
    endtask

    // R7: zero count ends at once without memory traffic.
    task automatic t_zero();
        clear_logs();
        @(negedge clk);
        cmd_word = mk(3'b001, 15'd0, 15'h0055, 3'b000); cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
        check("R7 disc next cycle", disc, 1);
        @(negedge clk);
        check("R7 idle after", busy, 0);
        check("R7 no mem", reqs, 0);
    endtask

    // R4: address wrap.
    task automatic t_wrap();
        clear_logs();
        src_en = 1'b1; src_limit = 3;
        issue(mk(3'b100, 15'd3, 15'h7FFF, 3'b000));
        wait_idle("R4");
        check("R4 addr0", wlog_a[0], 15'h7FFF);
        check("R4 addr1", wlog_a[1], 15'h0000);
        check("R4 addr2", wlog_a[2], 15'h0001);
        check("R4 req pulse", ends_req, 1);
    endtask

    // R8: no memory request while the device stalls.
    task automatic t_stall();
        clear_logs();
        src_limit = 2;
        issue(mk(3'b101, 15'd2, 15'h0010, 3'b000));
        repeat (20) @(negedge clk);
        check("R8 no mem during stall", reqs, 0);
        check("R8 still busy", busy, 1);
        src_en = 1'b1;
        wait_idle("R8");
        check("R8 writes after", wcnt, 2);
        check("R8 data", wlog_d[1], src_word(1));
    endtask

    // R9: reload mid-command.
    task automatic t_reload();
        clear_logs();
        src_en = 1'b1; src_limit = 1;
        issue(mk(3'b101, 15'd5, 15'h0040, 3'b000));
        repeat (10) @(negedge clk);
        check("R9 first word written", wcnt, 1);
        issue(mk(3'b000, 15'd2, 15'h0300, 3'b000));
        wait_idle("R9");
        check("R9 no further writes", wcnt, 1);
        check("R9 new reads", ocnt, 2);
        check("R9 new data0", olog_d[0], rd_word(15'h0300));
        check("R9 new data1", olog_d[1], rd_word(15'h0301));
        check("R9 req pulse", ends_req, 1);
        check("R9 no disc", ends_disc, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_input();
        t_output();
        t_zero();
        t_wrap();
        t_stall();
        t_reload();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule